// File: doc/BRIEF.md
# Speculative Register File with Deferred-Fault Tags

This block is a small register file where each entry holds a data word and a one-bit poison tag. The poison tag records a deferred memory exception. A command port issues one operation per cycle. The operations are arithmetic on two registers, an immediate write, an ordinary load, a speculative load and a check. Memory data for a load arrives on a response port in the same cycle as the load command, along with a fault flag.

A speculative load that faults does not trap. It tags its destination as poisoned. The poison then follows the data: any arithmetic result that reads a poisoned source is itself poisoned. One check on the last register of a dependent chain therefore covers every load that fed it. A check of a clean register does nothing. A check of a poisoned register emits a one-cycle redirect pulse that carries the recovery address given with the check. An ordinary load that faults raises a one-cycle trap pulse and leaves its destination untouched.

Top module: `poison_tracker`

## Requirements
- R1: After reset every register reads data 0 with a clear poison tag.
- R2: A speculative load (op code 4) without a fault writes the memory data to the destination and clears its poison tag.
- R3: A speculative load with a fault raises no trap, writes data 0 and sets the destination's poison tag.
- R4: Arithmetic ops add (op 1), subtract A minus B (op 2) and xor (op 3) write the result modulo 2^DW, and the destination's poison tag is the OR of both source tags.
- R5: An immediate write (op 7), a non-faulting ordinary load (op 5) or an arithmetic op with two clean sources leaves the destination clean, even when the destination was poisoned before.
- R6: An ordinary load (op 5) that faults pulses the trap output for exactly the one cycle after the command and changes neither the data nor the tag of its destination.
- R7: A check (op 6) of a poisoned source A drives the redirect output high for exactly the one cycle after the command, and the redirect target equals the command's immediate.
- R8: A check of a clean register drives no redirect, and a check changes no register.
- R9: Register 0 always reads data 0 with a clear tag, whatever is written to it.
- R10: One check at the end of a chain of dependent arithmetic ops redirects if any load at the root of the chain faulted, and stays quiet if none did.
- R11: With the command valid low, no register changes and neither the trap nor the redirect output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_dst | input | RW | Destination register |
| cmd_srca | input | RW | Source A (also the checked register) |
| cmd_srcb | input | RW | Source B |
| cmd_imm | input | DW | Immediate value or recovery address |
| mem_rdata | input | DW | Load response data |
| mem_fault | input | 1 | Load response fault flag |
| redirect_valid | output | 1 | One-cycle redirect to recovery |
| redirect_target | output | DW | Recovery address |
| trap_valid | output | 1 | One-cycle trap for a faulting ordinary load |
| rd_addr | input | RW | Observation read address |
| rd_data | output | DW | Observation read data |
| rd_poison | output | 1 | Observation read poison tag |

## Verification
The arithmetic ops run over every pair of source registers, including register 0 and the case where a source is also the destination. The register file at that point holds a mix of clean and poisoned entries, so the pairs cover clean/clean, clean/poisoned and poisoned/poisoned sources. This separates a wrong result or a wrong tag merge from a register that was simply never written. Loads are tried with the fault flag set and with it clear, in both the speculative and the ordinary form, which shows that the fault path differs between the two kinds of load. Chains that start from a faulting load and chains that start from a clean load are each ended by a single check, which shows whether the redirect decision really depends on the tag that travelled down the chain.

// File: rtl/pbt_pkg.sv
`timescale 1ns/1ps
package pbt_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_XOR = 3'd3,
    OP_SLD = 3'd4,
    OP_LD  = 3'd5,
    OP_CHK = 3'd6,
    OP_LDI = 3'd7
  } op_e;
endpackage

// File: rtl/pbt_rst_sync.sv
`timescale 1ns/1ps
module pbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pbt_regfile.sv
`timescale 1ns/1ps
module pbt_regfile #(
  parameter  int NREG = 8,
  parameter  int DW   = 16,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_poison,
  input  logic [RW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  output logic          ra_poison,
  input  logic [RW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  output logic          rb_poison,
  input  logic [RW-1:0] rc_addr,
  output logic [DW-1:0] rc_data,
  output logic          rc_poison
);
  logic [NREG-1:0][DW-1:0] data_v;
  logic [NREG-1:0]         pois_v;

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    if (g == 0) begin : g_zero
      assign data_v[g] = '0;
      assign pois_v[g] = 1'b0;
    end else begin : g_reg
      logic          cell_en;
      logic [DW-1:0] cell_data_q, cell_data_d;
      logic          cell_pois_q, cell_pois_d;

      assign cell_en = wr_en && (wr_addr == RW'(g));

      always_comb begin
        cell_data_d = cell_data_q;
        cell_pois_d = cell_pois_q;
        if (cell_en) begin
          cell_data_d = wr_data;
          cell_pois_d = wr_poison;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_data_q <= '0;
          cell_pois_q <= 1'b0;
        end else if (cell_en) begin
          cell_data_q <= cell_data_d;
          cell_pois_q <= cell_pois_d;
        end
      end

      assign data_v[g] = cell_data_q;
      assign pois_v[g] = cell_pois_q;
    end
  end

  assign ra_data   = data_v[ra_addr];
  assign ra_poison = pois_v[ra_addr];
  assign rb_data   = data_v[rb_addr];
  assign rb_poison = pois_v[rb_addr];
  assign rc_data   = data_v[rc_addr];
  assign rc_poison = pois_v[rc_addr];
endmodule

// File: rtl/pbt_exec.sv
`timescale 1ns/1ps
module pbt_exec
  import pbt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_imm,
  input  logic [DW-1:0] a_data,
  input  logic          a_poison,
  input  logic [DW-1:0] b_data,
  input  logic          b_poison,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_fault,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          wr_poison,
  output logic          trap_set,
  output logic          redir_set
);
  op_e op;
  assign op = op_e'(cmd_op);

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = '0;
    wr_poison = 1'b0;
    trap_set  = 1'b0;
    redir_set = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_ADD: begin
          wr_en     = 1'b1;
          wr_data   = a_data + b_data;
          wr_poison = a_poison | b_poison;
        end
        OP_SUB: begin
          wr_en     = 1'b1;
          wr_data   = a_data - b_data;
          wr_poison = a_poison | b_poison;
        end
        OP_XOR: begin
          wr_en     = 1'b1;
          wr_data   = a_data ^ b_data;
          wr_poison = a_poison | b_poison;
        end
        OP_SLD: begin
          wr_en     = 1'b1;
          wr_data   = mem_fault ? '0 : mem_rdata;
          wr_poison = mem_fault;
        end
        OP_LD: begin
          wr_en    = !mem_fault;
          wr_data  = mem_rdata;
          trap_set = mem_fault;
        end
        OP_CHK: begin
          redir_set = a_poison;
        end
        OP_LDI: begin
          wr_en   = 1'b1;
          wr_data = cmd_imm;
        end
        default: begin
          wr_en = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pbt_event_reg.sv
`timescale 1ns/1ps
module pbt_event_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_set,
  input  logic          redir_set,
  input  logic [DW-1:0] redir_addr,
  output logic          trap_q,
  output logic          redir_q,
  output logic [DW-1:0] target_q
);
  logic          trap_d, redir_d;
  logic [DW-1:0] target_d;

  always_comb begin
    trap_d   = trap_set;
    redir_d  = redir_set;
    target_d = redir_set ? redir_addr : target_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      redir_q <= 1'b0;
    end else begin
      trap_q  <= trap_d;
      redir_q <= redir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= '0;
    else if (redir_set) target_q <= target_d;
  end
endmodule

// File: rtl/poison_tracker.sv
`timescale 1ns/1ps
module poison_tracker #(
  parameter  int NREG = 8,
  parameter  int DW   = 16,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [RW-1:0] cmd_dst,
  input  logic [RW-1:0] cmd_srca,
  input  logic [RW-1:0] cmd_srcb,
  input  logic [DW-1:0] cmd_imm,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_fault,
  output logic          redirect_valid,
  output logic [DW-1:0] redirect_target,
  output logic          trap_valid,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_poison
);
  logic          rst_sync_n;
  logic [DW-1:0] a_data, b_data, wr_data;
  logic          a_poison, b_poison, wr_poison;
  logic          wr_en, trap_set, redir_set;

  pbt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbt_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (cmd_dst),
    .wr_data   (wr_data),
    .wr_poison (wr_poison),
    .ra_addr   (cmd_srca),
    .ra_data   (a_data),
    .ra_poison (a_poison),
    .rb_addr   (cmd_srcb),
    .rb_data   (b_data),
    .rb_poison (b_poison),
    .rc_addr   (rd_addr),
    .rc_data   (rd_data),
    .rc_poison (rd_poison)
  );

  pbt_exec #(.DW(DW)) u_exec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_imm   (cmd_imm),
    .a_data    (a_data),
    .a_poison  (a_poison),
    .b_data    (b_data),
    .b_poison  (b_poison),
    .mem_rdata (mem_rdata),
    .mem_fault (mem_fault),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_poison (wr_poison),
    .trap_set  (trap_set),
    .redir_set (redir_set)
  );

  pbt_event_reg #(.DW(DW)) u_evt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trap_set   (trap_set),
    .redir_set  (redir_set),
    .redir_addr (cmd_imm),
    .trap_q     (trap_valid),
    .redir_q    (redirect_valid),
    .target_q   (redirect_target)
  );
endmodule

// File: rtl/poison_tracker_chk.sv
`timescale 1ns/1ps
module poison_tracker_chk
  import pbt_pkg::*;
#(
  parameter  int NREG = 8,
  parameter  int DW   = 16,
  localparam int RW   = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [DW-1:0] cmd_imm,
  input logic          mem_fault,
  input logic          src_poison,
  input logic          redirect_valid,
  input logic [DW-1:0] redirect_target,
  input logic          trap_valid,
  input logic [RW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_poison
);
  AST_SPEC_LOAD_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SLD) |=> !trap_valid); // R3

  AST_LOAD_FAULT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LD && mem_fault) |=> trap_valid); // R6

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(cmd_valid && cmd_op == OP_LD && mem_fault)); // R6

  AST_CHK_POISON_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CHK && src_poison)
      |=> (redirect_valid && redirect_target == $past(cmd_imm))); // R7

  AST_CHK_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CHK && !src_poison) |=> !redirect_valid); // R8

  AST_REDIRECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(cmd_valid && cmd_op == OP_CHK)); // R7

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |-> (rd_data == '0 && !rd_poison)); // R9
endmodule

bind poison_tracker poison_tracker_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .cmd_valid       (cmd_valid),
  .cmd_op          (cmd_op),
  .cmd_imm         (cmd_imm),
  .mem_fault       (mem_fault),
  .src_poison      (a_poison),
  .redirect_valid  (redirect_valid),
  .redirect_target (redirect_target),
  .trap_valid      (trap_valid),
  .rd_addr         (rd_addr),
  .rd_data         (rd_data),
  .rd_poison       (rd_poison)
);

// File: tb/tb_poison_tracker.sv
`timescale 1ns/1ps
module tb_poison_tracker;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int RW   = 3;

  localparam logic [2:0] ADD = 3'd1, SUB = 3'd2, XOR = 3'd3, SLD = 3'd4,
                         LD = 3'd5, CHK = 3'd6, LDI = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [RW-1:0] cmd_dst, cmd_srca, cmd_srcb, rd_addr;
  logic [DW-1:0] cmd_imm, mem_rdata, redirect_target, rd_data;
  logic          mem_fault, redirect_valid, trap_valid, rd_poison;

  int n_chk  = 0;
  int n_fail = 0;

  logic [DW-1:0] m_data [NREG];
  logic          m_pois [NREG];

  always #10 clk = ~clk;

  poison_tracker #(.NREG(NREG), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
    .cmd_imm(cmd_imm), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .trap_valid(trap_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_poison(rd_poison)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input int r, input string tag);
    rd_addr = RW'(r);
    #1;
    chk(rd_data == m_data[r], tag, 32'(rd_data), 32'(m_data[r]));
    chk(rd_poison == m_pois[r], tag, 32'(rd_poison), 32'(m_pois[r]));
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < NREG; r++) check_reg(r, tag);
  endtask

  // Drives one command, applies the requirement-level model, and leaves
  // the bench at the falling edge after the command's clock edge.
  task automatic do_op(input logic [2:0] op, input int d, input int a, input int b,
                       input logic [DW-1:0] imm, input logic [DW-1:0] md,
                       input logic mf, input logic vld,
                       output logic exp_trap, output logic exp_redir);
    logic [DW-1:0] av, bv;
    logic          ap, bp;
    @(negedge clk);
    cmd_valid = vld; cmd_op = op; cmd_dst = RW'(d); cmd_srca = RW'(a);
    cmd_srcb = RW'(b); cmd_imm = imm; mem_rdata = md; mem_fault = mf;
    av = m_data[a]; bv = m_data[b]; ap = m_pois[a]; bp = m_pois[b];
    exp_trap = 1'b0; exp_redir = 1'b0;
    if (vld) begin
      case (op)
        ADD: begin if (d != 0) begin m_data[d] = av + bv; m_pois[d] = ap | bp; end end
        SUB: begin if (d != 0) begin m_data[d] = av - bv; m_pois[d] = ap | bp; end end
        XOR: begin if (d != 0) begin m_data[d] = av ^ bv; m_pois[d] = ap | bp; end end
        SLD: begin if (d != 0) begin m_data[d] = mf ? '0 : md; m_pois[d] = mf; end end
        LD:  begin
          if (mf) exp_trap = 1'b1;
          else if (d != 0) begin m_data[d] = md; m_pois[d] = 1'b0; end
        end
        CHK: exp_redir = ap;
        LDI: begin if (d != 0) begin m_data[d] = imm; m_pois[d] = 1'b0; end end
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0; mem_fault = 1'b0;
  endtask

  task automatic op_simple(input logic [2:0] op, input int d, input int a, input int b,
                           input logic [DW-1:0] imm, input logic [DW-1:0] md,
                           input logic mf);
    logic et, er;
    do_op(op, d, a, b, imm, md, mf, 1'b1, et, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic et, er;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_dst = '0; cmd_srca = '0;
    cmd_srcb = '0; cmd_imm = '0; mem_rdata = '0; mem_fault = 1'b0; rd_addr = '0;
    for (int r = 0; r < NREG; r++) begin m_data[r] = '0; m_pois[r] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset state");

    // R9: writes to register 0 are discarded
    op_simple(LDI, 0, 0, 0, 16'h1234, '0, 1'b0);
    check_reg(0, "R9 ldi to r0");
    op_simple(SLD, 0, 0, 0, '0, 16'h5555, 1'b1);
    check_reg(0, "R9 faulting spec load to r0");

    for (int r = 1; r < NREG; r++)
      op_simple(LDI, r, 0, 0, 16'((r * 16'h1111) ^ 16'h0F0F), '0, 1'b0);
    check_all("R5 immediate fill");

    // R3: faulting speculative loads
    for (int r = 5; r <= 6; r++) begin
      do_op(SLD, r, 0, 0, '0, 16'hA5A5, 1'b1, 1'b1, et, er);
      chk(trap_valid == 1'b0, "R3 no trap", 32'(trap_valid), 0);
      check_reg(r, "R3 poisoned dest");
    end
    // R2: clean speculative load
    do_op(SLD, 4, 0, 0, '0, 16'hC3C3, 1'b0, 1'b1, et, er);
    chk(trap_valid == 1'b0, "R2 no trap", 32'(trap_valid), 0);
    check_reg(4, "R2 clean spec load");

    // R4: sweep of all source pairs for every arithmetic op
    for (int o = 1; o <= 3; o++)
      for (int a = 0; a < NREG; a++)
        for (int b = 0; b < NREG; b++) begin
          int d;
          d = 1 + ((a * 3 + b + o) % (NREG - 1));
          op_simple(3'(o), d, a, b, '0, '0, 1'b0);
          check_reg(d, "R4 arithmetic result and tag");
        end

    // R5: poisoned destinations become clean again
    op_simple(LDI, 1, 0, 0, 16'h0101, '0, 1'b0);
    op_simple(LDI, 2, 0, 0, 16'h0202, '0, 1'b0);
    op_simple(SLD, 7, 0, 0, '0, '0, 1'b1);
    check_reg(7, "R5 setup poison");
    op_simple(ADD, 7, 1, 2, '0, '0, 1'b0);
    check_reg(7, "R5 clean add clears poison");
    op_simple(SLD, 6, 0, 0, '0, '0, 1'b1);
    op_simple(LD, 6, 0, 0, '0, 16'h7E57, 1'b0);
    check_reg(6, "R5 ordinary load clears poison");
    op_simple(SLD, 5, 0, 0, '0, '0, 1'b1);
    op_simple(LDI, 5, 0, 0, 16'h00AA, '0, 1'b0);
    check_reg(5, "R5 immediate clears poison");

    // R6: faulting ordinary load traps for one cycle and writes nothing
    op_simple(SLD, 3, 0, 0, '0, '0, 1'b1);
    do_op(LD, 3, 0, 0, '0, 16'hDEAD, 1'b1, 1'b1, et, er);
    chk(trap_valid == et, "R6 trap pulse", 32'(trap_valid), 32'(et));
    check_reg(3, "R6 dest untouched");
    @(negedge clk);
    chk(trap_valid == 1'b0, "R6 trap single cycle", 32'(trap_valid), 0);
    do_op(LD, 4, 0, 0, '0, 16'hDEAF, 1'b1, 1'b1, et, er);
    chk(trap_valid == 1'b1, "R6 trap on clean dest", 32'(trap_valid), 1);
    check_reg(4, "R6 clean dest untouched");

    // R10 / R7: chain rooted at a faulting speculative load
    op_simple(SLD, 1, 0, 0, '0, '0, 1'b1);
    op_simple(ADD, 2, 1, 5, '0, '0, 1'b0);
    op_simple(XOR, 4, 7, 2, '0, '0, 1'b0);
    op_simple(SUB, 6, 4, 7, '0, '0, 1'b0);
    check_reg(6, "R10 chain end poisoned");
    do_op(CHK, 0, 6, 0, 16'hBEEF, '0, 1'b0, 1'b1, et, er);
    chk(redirect_valid == 1'b1, "R7 redirect on poisoned check", 32'(redirect_valid), 1);
    chk(redirect_target == 16'hBEEF, "R7 redirect target", 32'(redirect_target), 32'hBEEF);
    check_all("R8 check changes no register");
    @(negedge clk);
    chk(redirect_valid == 1'b0, "R7 redirect single cycle", 32'(redirect_valid), 0);

    // R10 / R8: chain rooted at a clean speculative load
    op_simple(SLD, 1, 0, 0, '0, 16'h0033, 1'b0);
    op_simple(LDI, 5, 0, 0, 16'h0044, '0, 1'b0);
    op_simple(LDI, 7, 0, 0, 16'h0055, '0, 1'b0);
    op_simple(ADD, 2, 1, 5, '0, '0, 1'b0);
    op_simple(XOR, 4, 7, 2, '0, '0, 1'b0);
    op_simple(SUB, 6, 4, 7, '0, '0, 1'b0);
    check_reg(6, "R10 clean chain value");
    do_op(CHK, 0, 6, 0, 16'h1111, '0, 1'b0, 1'b1, et, er);
    chk(redirect_valid == 1'b0, "R8 clean check quiet", 32'(redirect_valid), 0);
    do_op(CHK, 0, 0, 0, 16'h2222, '0, 1'b0, 1'b1, et, er);
    chk(redirect_valid == 1'b0, "R8 check of r0 quiet", 32'(redirect_valid), 0);
    check_all("R8 registers after clean checks");

    // R11: invalid commands have no effect
    op_simple(SLD, 3, 0, 0, '0, '0, 1'b1);
    do_op(LDI, 3, 0, 0, 16'h9999, '0, 1'b0, 1'b0, et, er);
    check_reg(3, "R11 invalid immediate ignored");
    do_op(LD, 2, 0, 0, '0, 16'h8888, 1'b1, 1'b0, et, er);
    chk(trap_valid == 1'b0, "R11 invalid load no trap", 32'(trap_valid), 0);
    do_op(CHK, 0, 3, 0, 16'h7777, '0, 1'b0, 1'b0, et, er);
    chk(redirect_valid == 1'b0, "R11 invalid check no redirect", 32'(redirect_valid), 0);
    check_all("R11 state after invalid commands");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule